// File: doc/BRIEF.md
# Packed Horizontal Add/Subtract Unit

This block is a SIMD datapath that reduces neighbouring element pairs inside each of two packed operands, A and B, and concatenates the reduced values into one packed result. Each element pair is either added or subtracted. The lanes are either 16 or 32 bits wide. For 16-bit lanes, an optional mode clamps each result to the signed 16-bit range. The operand width `DATA_W` is a parameter and must be 64 or 128.

The pair arithmetic is combinational. A single register stage follows it. A request is qualified by `vld_i`. The result and `vld_o` appear on the clock edge after the request is sampled. The output register keeps its contents while no request arrives. Instruction decode, register files and memory operands belong to the surrounding pipeline.

Top module: `hpair_unit`

## Requirements
- R1: The output lanes are numbered upward from bit 0. With `lane_sz_i`=0 (16-bit lanes), output lane k for k < DATA_W/32 holds the result of A lanes 2k and 2k+1. Output lane DATA_W/32+k holds the result of B lanes 2k and 2k+1. The 32-bit lane mode uses the same layout with 32-bit lanes.
- R2: When `op_sub_i`=1, each result is the even lane minus the odd lane (lane 2k − lane 2k+1). When `op_sub_i`=0, each result is the sum of the two lanes.
- R3: With `lane_sz_i`=0 and `sat_i`=0, each result wraps modulo 2^16. For example, 0x7FFF+0x0001 gives 0x8000.
- R4: With `lane_sz_i`=1 (32-bit lanes), each result wraps modulo 2^32.
- R5: With `lane_sz_i`=0 and `sat_i`=1, the exact 17-bit result is clamped. Values below −32768 become 0x8000, values above 32767 become 0x7FFF, and all other values pass through unchanged.
- R6: With `lane_sz_i`=1, `sat_i` has no effect and no clamp takes place.
- R7: `vld_o` is 1 exactly in the cycle after a cycle with `vld_i`=1. `res_o` then holds the result of that request.
- R8: While `vld_i`=0, `res_o` keeps its value.
- R9: While `rst_n` is low at a clock edge, `vld_o` is cleared to 0 and `res_o` is cleared to 0.
- R10: Both `DATA_W`=64 and `DATA_W`=128 follow R1 to R6 for their own widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Request strobe |
| op_sub_i | input | 1 | 1 = subtract even minus odd, 0 = add |
| lane_sz_i | input | 1 | 0 = 16-bit lanes, 1 = 32-bit lanes |
| sat_i | input | 1 | Signed 16-bit saturation enable (16-bit lanes only) |
| a_i | input | DATA_W | Packed operand A |
| b_i | input | DATA_W | Packed operand B |
| vld_o | output | 1 | Result valid |
| res_o | output | DATA_W | Packed result |

## Verification
The bench sends values on both sides of each clamp threshold, and also the case −32768 − 32767. A design that clamps from a 16-bit intermediate would miss the overflow in these cases and return a wrapped value with the wrong sign.

Subtracting from unequal lanes catches a swapped operand order, which shows up as a negated result. Swapped halves show up when A and B carry distinct pair sums. A design that let saturation leak into 32-bit mode would return 0x7FFFFFFF instead of 0x80000000.

The checks run against both a 64-bit and a 128-bit instance, so half-width indexing mistakes show up in one instance or the other. Hold checks change the operands while `vld_i` is low, which exposes an output register that loads on every cycle.

// File: rtl/hpair_pkg.sv
package hpair_pkg;

  localparam int WORD_W  = 16;
  localparam int DWORD_W = 32;

  typedef enum logic {
    LANE_W16 = 1'b0,
    LANE_W32 = 1'b1
  } lane_sz_e;

  // exact 17-bit sum or difference of two signed words
  function automatic logic [WORD_W:0] pair16_wide(input logic [WORD_W-1:0] ev,
                                                   input logic [WORD_W-1:0] od,
                                                   input logic sub);
    logic [WORD_W:0] e;
    logic [WORD_W:0] o;
    e = {ev[WORD_W-1], ev};
    o = {od[WORD_W-1], od};
    return sub ? (e - o) : (e + o);
  endfunction

  // clamp a 17-bit signed value into the signed word range
  function automatic logic [WORD_W-1:0] clamp16(input logic [WORD_W:0] s);
    if (s[WORD_W] != s[WORD_W-1])
      return s[WORD_W] ? {1'b1, {(WORD_W-1){1'b0}}} : {1'b0, {(WORD_W-1){1'b1}}};
    return s[WORD_W-1:0];
  endfunction

  function automatic logic [DWORD_W-1:0] pair32(input logic [DWORD_W-1:0] ev,
                                                 input logic [DWORD_W-1:0] od,
                                                 input logic sub);
    return sub ? (ev - od) : (ev + od);
  endfunction

endpackage

// File: rtl/hpair_word16.sv
module hpair_word16
  import hpair_pkg::*;
(
  input  logic [WORD_W-1:0] ev_i,
  input  logic [WORD_W-1:0] od_i,
  input  logic              sub_i,
  input  logic              sat_en_i,
  output logic [WORD_W-1:0] res_o,
  output logic              clamp_o
);
  logic [WORD_W:0] wide;

  assign wide    = pair16_wide(ev_i, od_i, sub_i);
  assign clamp_o = sat_en_i & (wide[WORD_W] ^ wide[WORD_W-1]);
  assign res_o   = sat_en_i ? clamp16(wide) : wide[WORD_W-1:0];
endmodule

// File: rtl/hpair_dword32.sv
module hpair_dword32
  import hpair_pkg::*;
(
  input  logic [DWORD_W-1:0] ev_i,
  input  logic [DWORD_W-1:0] od_i,
  input  logic               sub_i,
  output logic [DWORD_W-1:0] res_o
);
  assign res_o = pair32(ev_i, od_i, sub_i);
endmodule

// File: rtl/hpair_pipe.sv
module hpair_pipe #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/hpair_unit.sv
module hpair_unit
  import hpair_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic              op_sub_i,
  input  logic              lane_sz_i,
  input  logic              sat_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] res_o
);
  localparam int NP16 = DATA_W / (2 * WORD_W);   // word pairs per operand
  localparam int NP32 = DATA_W / (2 * DWORD_W);  // dword pairs per operand

  logic              sat_en;
  logic [DATA_W-1:0] res16;
  logic [DATA_W-1:0] res32;
  logic [DATA_W-1:0] res_next;
  logic [2*NP16-1:0] clamp_vec;
  logic              clamp_any;

  // saturation only applies to 16-bit lanes
  assign sat_en = sat_i & (lane_sz_i == LANE_W16);

  for (genvar i = 0; i < 2 * NP16; i++) begin : g_w16
    localparam int J = (i < NP16) ? i : i - NP16;
    logic [DATA_W-1:0] src;
    assign src = (i < NP16) ? a_i : b_i;
    hpair_word16 u_w (
      .ev_i    (src[2*WORD_W*J +: WORD_W]),
      .od_i    (src[2*WORD_W*J+WORD_W +: WORD_W]),
      .sub_i   (op_sub_i),
      .sat_en_i(sat_en),
      .res_o   (res16[WORD_W*i +: WORD_W]),
      .clamp_o (clamp_vec[i])
    );
  end

  for (genvar i = 0; i < 2 * NP32; i++) begin : g_w32
    localparam int J = (i < NP32) ? i : i - NP32;
    logic [DATA_W-1:0] src;
    assign src = (i < NP32) ? a_i : b_i;
    hpair_dword32 u_d (
      .ev_i (src[2*DWORD_W*J +: DWORD_W]),
      .od_i (src[2*DWORD_W*J+DWORD_W +: DWORD_W]),
      .sub_i(op_sub_i),
      .res_o(res32[DWORD_W*i +: DWORD_W])
    );
  end

  assign clamp_any = |clamp_vec;
  assign res_next  = (lane_sz_i == LANE_W32) ? res32 : res16;

  hpair_pipe #(.W(DATA_W)) u_pipe (
    .clk  (clk),
    .rst_n(rst_n),
    .vld_i(vld_i),
    .d_i  (res_next),
    .vld_o(vld_o),
    .q_o  (res_o)
  );
endmodule

// File: rtl/hpair_unit_chk.sv
module hpair_unit_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vld_i,
  input logic              op_sub_i,
  input logic              lane_sz_i,
  input logic              sat_i,
  input logic [DATA_W-1:0] a_i,
  input logic              vld_o,
  input logic [DATA_W-1:0] res_o,
  input logic              clamp_any
);
  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o);

  // R7
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_o);

  // R8
  hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(res_o));

  // R6
  no_clamp_w32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && lane_sz_i && sat_i) |-> !clamp_any);

  // R2
  sub_equal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && op_sub_i && !lane_sz_i && (a_i[15:0] == a_i[31:16])) |=> (res_o[15:0] == 16'h0));

  // R5
  sat_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !op_sub_i && !lane_sz_i && sat_i && !a_i[15] && !a_i[31]) |=> !res_o[15]);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!vld_o && (res_o == '0)));
endmodule

bind hpair_unit hpair_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .vld_i    (vld_i),
  .op_sub_i (op_sub_i),
  .lane_sz_i(lane_sz_i),
  .sat_i    (sat_i),
  .a_i      (a_i),
  .vld_o    (vld_o),
  .res_o    (res_o),
  .clamp_any(clamp_any)
);

// File: tb/hpair_unit_tb_top.sv
module hpair_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vld = 1'b0;
  logic         sub = 1'b0;
  logic         l32 = 1'b0;
  logic         sat = 1'b0;
  logic [127:0] a = '0;
  logic [127:0] b = '0;
  logic         vo128, vo64;
  logic [127:0] r128;
  logic [63:0]  r64;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  hpair_unit #(.DATA_W(128)) dut_i (
    .clk(clk), .rst_n(rst_n), .vld_i(vld), .op_sub_i(sub), .lane_sz_i(l32),
    .sat_i(sat), .a_i(a), .b_i(b), .vld_o(vo128), .res_o(r128));

  hpair_unit #(.DATA_W(64)) dut64_i (
    .clk(clk), .rst_n(rst_n), .vld_i(vld), .op_sub_i(sub), .lane_sz_i(l32),
    .sat_i(sat), .a_i(a[63:0]), .b_i(b[63:0]), .vld_o(vo64), .res_o(r64));

  // reference: walk output lanes, pick the source operand and pair
  function automatic logic [127:0] ref_hop(input logic [127:0] xa, input logic [127:0] xb,
                                           input logic s, input logic w32, input logic st,
                                           input int w);
    logic [127:0] out;
    int lw, n, half;
    out  = '0;
    lw   = w32 ? 32 : 16;
    n    = w / lw;
    half = n / 2;
    for (int k = 0; k < n; k++) begin
      logic [127:0] src;
      longint e, o, v;
      int j;
      src = (k < half) ? xa : xb;
      j   = (k < half) ? k : k - half;
      if (w32) begin
        e = longint'($signed(src[2*j*32 +: 32]));
        o = longint'($signed(src[(2*j+1)*32 +: 32]));
      end else begin
        e = longint'($signed(src[2*j*16 +: 16]));
        o = longint'($signed(src[(2*j+1)*16 +: 16]));
      end
      v = s ? e - o : e + o;
      if (!w32 && st) begin
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
      end
      if (w32) out[k*32 +: 32] = v[31:0];
      else     out[k*16 +: 16] = v[15:0];
    end
    return out;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; outputs compared at the following negedge
  task automatic run(input string tag, input logic [127:0] xa, input logic [127:0] xb,
                     input logic s, input logic w32, input logic st);
    logic [127:0] e128, e64;
    @(negedge clk);
    a = xa; b = xb; sub = s; l32 = w32; sat = st; vld = 1'b1;
    e128 = ref_hop(xa, xb, s, w32, st, 128);
    e64  = ref_hop(xa, xb, s, w32, st, 64);
    @(negedge clk);
    vld = 1'b0;
    check({tag, " R7 vld128"}, {127'b0, vo128}, 128'd1);
    check({tag, " R7 vld64"}, {127'b0, vo64}, 128'd1);
    check({tag, " w128"}, r128, e128);
    check({tag, " R10 w64"}, {64'b0, r64}, e64);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset vld128", {127'b0, vo128}, 128'd0);
    check("R9 reset res128", r128, 128'd0);
    check("R9 reset vld64", {127'b0, vo64}, 128'd0);
    rst_n = 1'b1;

    // R1 layout: distinct pair sums in A and B
    run("R1 add16", {16'd8, 16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1},
        {16'd80, 16'd70, 16'd60, 16'd50, 16'd40, 16'd30, 16'd20, 16'd10}, 0, 0, 0);
    check("R1 lane0", {112'b0, r128[15:0]}, 128'd3);
    check("R1 lane4", {112'b0, r128[79:64]}, 128'd30);
    // R2 even minus odd: a0=5, a1=3 -> 2
    run("R2 sub16", {96'b0, 16'd3, 16'd5}, 128'b0, 1, 0, 0);
    check("R2 order", {112'b0, r128[15:0]}, 128'd2);
    // R3 wrap
    run("R3 wrap16", {96'b0, 16'h0001, 16'h7FFF}, 128'b0, 0, 0, 0);
    check("R3 lane0", {112'b0, r128[15:0]}, 128'h8000);
    // R5 clamps
    run("R5 satpos", {96'b0, 16'h0001, 16'h7FFF}, 128'b0, 0, 0, 1);
    check("R5 pos", {112'b0, r128[15:0]}, 128'h7FFF);
    run("R5 satneg", {96'b0, 16'h7FFF, 16'h8000}, 128'b0, 1, 0, 1);
    check("R5 neg", {112'b0, r128[15:0]}, 128'h8000);
    run("R5 satmid", {96'b0, 16'h8000, 16'h8000}, {96'b0, 16'h0001, 16'h7FFE}, 1, 0, 1);
    // R4 32-bit wrap, R6 saturation ignored
    run("R4 wrap32", {64'b0, 32'h0000_0001, 32'h7FFF_FFFF}, 128'b0, 0, 1, 0);
    run("R6 sat32", {64'b0, 32'h0000_0001, 32'h7FFF_FFFF}, 128'b0, 0, 1, 1);
    check("R6 lane0", {96'b0, r128[31:0]}, 128'h8000_0000);
    run("R4 sub32", {32'd1, 32'd9, 32'd4, 32'd7}, {32'd2, 32'd1, 32'd5, 32'd5}, 1, 1, 0);

    // R8 hold while idle with changing inputs
    held = r128;
    a = ~a; b = ~b; sub = ~sub;
    repeat (2) @(negedge clk);
    check("R8 hold", r128, held);
    check("R7 idle vld", {127'b0, vo128}, 128'd0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [127:0] ra, rb;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      if (it % 5 == 0) begin
        ra[15:0]  = 16'h7F00 | 16'($urandom & 32'hFF);
        ra[31:16] = 16'h7F00 | 16'($urandom & 32'hFF);
      end
      run("R1 R3 R5 rnd", ra, rb, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule